// File: doc/BRIEF.md
# Two-Class Push-In Crosspoint Queue

This block is a bounded queue of packet descriptors for a single crosspoint of a buffered crossbar. Each descriptor carries a payload tag and a one-bit class. High-class descriptors are inserted at the boundary between the classes, so they always sit ahead of every held low-class descriptor. Low-class descriptors join at the tail. Reads always take the head. Each class therefore keeps its arrival order, and the output scheduler sees a high-class head whenever one is held.

The enqueue side has no back-pressure. Every cycle with `enq_valid` high is one push attempt. The attempt is either stored or lost, and a loss is reported on `drop`. When a high-class push meets a full queue that still holds low-class entries, the newest low-class entry is evicted to make room. The dequeue side is valid/ready. `empty` low is the valid indication. A pop happens on a rising clock edge where `deq_ready` is high and `empty` is low. `deq_ready` may be held high while the queue is empty, and nothing happens then. In a cycle with both a pop and a push, the pop is applied first.

Top module: `prio_insert_queue`

## Requirements
- R1: `enq_prio` = 1 marks a high-class descriptor and 0 marks a low-class one. `deq_prio` gives the class of the head entry, and it is 0 whenever `empty` is 1.
- R2: A low-class push into a queue that is not full stores the tag at the tail, behind every held entry.
- R3: A high-class push into a queue that is not full stores the tag behind every held high-class entry and ahead of every held low-class entry.
- R4: With `deq_ready` high and `empty` low, the head entry is removed at the clock edge. With `deq_ready` high while `empty` is 1, the queue stays unchanged.
- R5: Within each class, descriptors leave in the order they were pushed.
- R6: A high-class push into a full queue that holds at least one low-class entry evicts the tail low-class entry, inserts the new tag as in R3, leaves the queue full, and raises `drop` for one cycle.
- R7: A high-class push into a full queue that holds only high-class entries is rejected, and `drop` is high for one cycle.
- R8: A low-class push into a full queue is rejected, and `drop` is high for one cycle.
- R9: When a pop and a push occur in the same cycle, the pop is applied first. A push into a full queue is then stored without loss.
- R10: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held. Both outputs and `drop` are registered, and they reflect the result of the most recent clock edge.
- R11: After reset the queue is empty: `empty` = 1, `full` = 0, `drop` = 0 and `deq_prio` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Push attempt this cycle |
| enq_prio | input | 1 | Class of the pushed descriptor (1 high, 0 low) |
| enq_tag | input | TAG_W | Payload tag of the pushed descriptor |
| deq_ready | input | 1 | Consumer takes the head this cycle |
| deq_tag | output | TAG_W | Tag of the head entry |
| deq_prio | output | 1 | Class of the head entry, 0 when empty |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held; its inverse is the dequeue valid |
| drop | output | 1 | A descriptor was lost (rejected or evicted) at the previous edge |

## Verification
The properties assume that `enq_prio` and `enq_tag` carry defined values whenever `enq_valid` is high. They also treat `deq_ready` as free to rise in any cycle, empty or not. No property depends on how the classes mix, so the stimulus draws valid, class, tag and ready independently from `$urandom` with a fixed seed. It changes the bias between fill-heavy and drain-heavy phases so that full-queue eviction, rejection and same-cycle pop-and-push all occur often. Directed sequences before the random phase build the all-low full queue, the all-high full queue and the pop-on-empty case on purpose.

// File: rtl/piq_pkg.sv
package piq_pkg;
  // Outcome of one push attempt, after the same-cycle pop is applied.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_STORE = 2'd1,
    ACT_EVICT = 2'd2,
    ACT_LOSE  = 2'd3
  } enq_act_e;
endpackage

// File: rtl/piq_ctrl.sv
module piq_ctrl
  import piq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_prio,
  input  logic             deq_ready,
  output logic             do_pop,
  output logic             do_ins,
  output logic [PTR_W-1:0] ins_pos,
  output logic             head_hi,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, hcnt_q;
  logic [CNT_W-1:0] cnt_mid, hcnt_mid, cnt_d, hcnt_d;
  logic             room, has_low;
  enq_act_e         act;
  logic             drop_q;

  assign head_hi = (hcnt_q != '0);
  assign do_pop  = deq_ready && (cnt_q != '0);

  // Occupancy once the pop of this cycle has been applied.
  assign cnt_mid  = cnt_q - CNT_W'(do_pop);
  assign hcnt_mid = hcnt_q - CNT_W'(do_pop && head_hi);
  assign room     = (cnt_mid != CAP);
  assign has_low  = (hcnt_mid != cnt_mid);

  always_comb begin
    act = ACT_IDLE;
    if (enq_valid) begin
      if (room)                 act = ACT_STORE;
      else if (enq_prio && has_low) act = ACT_EVICT;
      else                      act = ACT_LOSE;
    end
  end

  assign do_ins  = (act == ACT_STORE) || (act == ACT_EVICT);
  assign ins_pos = enq_prio ? hcnt_mid[PTR_W-1:0] : cnt_mid[PTR_W-1:0];

  assign cnt_d  = cnt_mid + CNT_W'(act == ACT_STORE);
  assign hcnt_d = hcnt_mid + CNT_W'(do_ins && enq_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hcnt_q <= '0;
      drop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hcnt_q <= hcnt_d;
      drop_q <= (act == ACT_EVICT) || (act == ACT_LOSE);
    end
  end

  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);
  assign drop  = drop_q;
endmodule

// File: rtl/piq_store.sv
module piq_store #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_pop,
  input  logic             do_ins,
  input  logic [PTR_W-1:0] ins_pos,
  input  logic [TAG_W-1:0] ins_tag,
  output logic [TAG_W-1:0] head_tag
);
  logic [TAG_W-1:0] slot_q [DEPTH];
  logic [TAG_W-1:0] mid    [DEPTH];
  logic [TAG_W-1:0] nxt    [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    // Pop stage: everything moves one place toward the head.
    if (k == DEPTH - 1) begin : g_top
      assign mid[k] = do_pop ? '0 : slot_q[k];
    end else begin : g_inner
      assign mid[k] = do_pop ? slot_q[k+1] : slot_q[k];
    end

    // Insert stage: slots at and above the insert point move one place back.
    if (k == 0) begin : g_first
      always_comb begin
        if (do_ins && ins_pos == '0) nxt[k] = ins_tag;
        else                         nxt[k] = mid[k];
      end
    end else begin : g_rest
      always_comb begin
        if (!do_ins || (PTR_W'(k) < ins_pos)) nxt[k] = mid[k];
        else if (PTR_W'(k) == ins_pos)        nxt[k] = ins_tag;
        else                                  nxt[k] = mid[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= '0;
      else        slot_q[k] <= nxt[k];
    end
  end

  assign head_tag = slot_q[0];
endmodule

// File: rtl/prio_insert_queue.sv
module prio_insert_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_prio,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic             deq_ready,
  output logic [TAG_W-1:0] deq_tag,
  output logic             deq_prio,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             do_pop, do_ins, head_hi;
  logic [PTR_W-1:0] ins_pos;

  piq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_prio  (enq_prio),
    .deq_ready (deq_ready),
    .do_pop    (do_pop),
    .do_ins    (do_ins),
    .ins_pos   (ins_pos),
    .head_hi   (head_hi),
    .full      (full),
    .empty     (empty),
    .drop      (drop)
  );

  piq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_pop   (do_pop),
    .do_ins   (do_ins),
    .ins_pos  (ins_pos),
    .ins_tag  (enq_tag),
    .head_tag (deq_tag)
  );

  assign deq_prio = head_hi;
endmodule

// File: rtl/piq_checker.sv
module piq_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_prio,
  input logic [TAG_W-1:0] enq_tag,
  input logic             deq_ready,
  input logic [TAG_W-1:0] deq_tag,
  input logic             deq_prio,
  input logic             full,
  input logic             empty,
  input logic             drop
);
  assert_empty_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !deq_prio);

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_low_into_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && enq_valid && !enq_prio) |=> (!empty && !deq_prio && deq_tag == $past(enq_tag)));

  assert_high_to_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_prio && !full) |=> (!empty && deq_prio));

  assert_pop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && deq_ready && !enq_valid) |=> (!full && !drop));

  // R6 and R7: a high push into a full queue keeps it full, puts a high entry at the head, and loses a descriptor
  assert_high_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !deq_ready && enq_valid && enq_prio) |=> (full && deq_prio && drop));

  assert_low_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !deq_ready && enq_valid && !enq_prio) |=> (full && drop));

  assert_swap_no_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && deq_ready && enq_valid) |=> (full && !drop));

  assert_quiet_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_valid |=> !drop);
endmodule

bind prio_insert_queue piq_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_prio  (enq_prio),
  .enq_tag   (enq_tag),
  .deq_ready (deq_ready),
  .deq_tag   (deq_tag),
  .deq_prio  (deq_prio),
  .full      (full),
  .empty     (empty),
  .drop      (drop)
);

// File: tb/prio_insert_queue_tb_top.sv
`timescale 1ns/1ps
module prio_insert_queue_tb_top;
  localparam int D = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0;
  logic          enq_prio = 1'b0;
  logic [TW-1:0] enq_tag = '0;
  logic          deq_ready = 1'b0;
  logic [TW-1:0] deq_tag;
  logic          deq_prio, full, empty, drop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference contents: index 0 is the head.
  int mq [D];
  int mcnt = 0;
  int mhcnt = 0;
  bit mdrop = 1'b0;

  always #2.5 clk = ~clk;

  prio_insert_queue #(.DEPTH(D), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_prio(enq_prio),
    .enq_tag(enq_tag), .deq_ready(deq_ready), .deq_tag(deq_tag),
    .deq_prio(deq_prio), .full(full), .empty(empty), .drop(drop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected effect of one cycle: the pop first, then the push.
  task automatic model_apply(input bit v, input bit p, input int t, input bit r);
    int pos;
    mdrop = 1'b0;
    if (r && mcnt > 0) begin
      if (mhcnt > 0) mhcnt--;
      for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (v) begin
      if (!p) begin
        if (mcnt < D) begin mq[mcnt] = t; mcnt++; end
        else mdrop = 1'b1;
      end else if (mcnt < D || mhcnt < D) begin
        if (mcnt == D) mdrop = 1'b1;
        else mcnt++;
        pos = mhcnt;
        for (int i = D - 1; i > pos; i--) mq[i] = mq[i-1];
        mq[pos] = t;
        mhcnt++;
      end else begin
        mdrop = 1'b1;
      end
    end
  endtask

  task automatic step(input bit v, input bit p, input int t, input bit r, input string req);
    @(negedge clk);
    enq_valid = v; enq_prio = p; enq_tag = TW'(t); deq_ready = r;
    model_apply(v, p, t, r);
    @(posedge clk);
    #1;
    chk("R10", "empty", int'(empty), int'(mcnt == 0));
    chk("R10", "full", int'(full), int'(mcnt == D));
    chk("R1", "deq_prio", int'(deq_prio), int'(mhcnt > 0));
    chk(req, "drop", int'(drop), int'(mdrop));
    if (mcnt > 0) chk(req, "deq_tag", int'(deq_tag), mq[0]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "empty", int'(empty), 1);
    chk("R11", "full", int'(full), 0);
    chk("R11", "drop", int'(drop), 0);
    chk("R11", "deq_prio", int'(deq_prio), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: a pop request on an empty queue changes nothing
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, "R4");

    // R2 and R3: mixed pushes, then the drain shows the order (R5)
    step(1, 0, 10, 0, "R2");
    step(1, 0, 11, 0, "R2");
    step(1, 1, 20, 0, "R3");
    step(1, 1, 21, 0, "R3");
    step(1, 0, 12, 0, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, "R5");

    // R8: fill with low entries, then a low push is rejected
    for (int i = 0; i < D; i++) step(1, 0, 40 + i, 0, "R2");
    step(1, 0, 99, 0, "R8");
    // R6: each high push evicts the newest low entry until none remain
    for (int i = 0; i < D; i++) step(1, 1, 60 + i, 0, "R6");
    // R7: all entries are high now, so a high push is rejected
    step(1, 1, 98, 0, "R7");
    // R9: a pop and a push in the same cycle on a full queue
    step(1, 0, 77, 1, "R9");
    step(1, 1, 78, 1, "R9");
    for (int i = 0; i < D + 1; i++) step(0, 0, 0, 1, "R5");

    // Random phases, alternating between fill bias and drain bias
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 12; ph++) begin
      int vpct = (ph % 2 == 0) ? 85 : 45;
      int rpct = (ph % 2 == 0) ? 30 : 70;
      int hpct = 20 + (ph * 6);
      for (int i = 0; i < 250; i++) begin
        bit v = ($urandom % 100) < vpct;
        bit p = ($urandom % 100) < hpct;
        bit r = ($urandom % 100) < rpct;
        int t = int'($urandom % 256);
        step(v, p, t, r, "R5");
      end
    end
    for (int i = 0; i < D + 1; i++) step(0, 0, 0, 1, "R5");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule